// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control engine that carries out the memory work of taking an interrupt and of returning from one. The engine is given an 8-bit interrupt type and a snapshot of the running program's state: program counter, code segment, stack segment, stack pointer, flags and the current fill of the instruction prefetch queue. It then fetches the handler's address from a vector table that sits in segment zero. It stores the flags, the code segment and a corrected return address on the stack, and presents the new code segment, program counter, stack pointer and flags.

A return command runs the stack steps in reverse. A reset command loads the fixed start-up values at once. Memory is reached through one word-wide port with a request/acknowledge handshake, so any number of wait states is tolerated. Prefetch is held off for the whole sequence and restarted by a one-cycle flush pulse when the new fetch address is ready.

States and transitions. `ST_IDLE` waits for a command. An entry command moves to `ST_VEC_PC` (vector table word 0), then `ST_VEC_CS` (vector table word 1), then `ST_PUSH_FL`, then `ST_PUSH_CS`, then `ST_PUSH_PC`, and then back to `ST_IDLE`. A return command moves to `ST_POP_PC`, then `ST_POP_CS`, then `ST_POP_FL`, and then back to `ST_IDLE`. Each memory state advances only on a clock edge where its request is acknowledged. A reset command, and the unused code, leave the machine in `ST_IDLE`.

Top module: `int_sequencer`

## Requirements
- R1: After `rst_n` is released, `new_cs` is 0xFFFF and `new_pc`, `new_sp` and `new_flags` are 0. `done`, `pf_flush`, `seg_clear`, `pf_suspend` and `mem_req` are all low.
- R2: The command `cmd_op` is sampled with `cmd_start` in idle, using 2'b00 = entry, 2'b01 = return, 2'b10 = reset and 2'b11 = no action. An entry first performs two reads from segment 0: one at offset type*4, whose data becomes the new PC, and one at type*4+2, whose data becomes the new CS.
- R3: After the vector reads, an entry performs three writes to segment `cur_ss`, at sp-2, sp-4 and sp-6 (all modulo 2^16), holding flags, code segment and return address in that order. `new_sp` becomes sp-6.
- R4: The flags word written to the stack is `cur_flags` unchanged. After an entry, `new_flags` equals `cur_flags` with bit 9 (interrupt enable) and bit 8 (trap) cleared.
- R5: The return address written to the stack is `cur_pc` minus `queue_len`, modulo 2^16.
- R6: `pf_suspend` rises in the cycle after an accepted entry or return command and stays high until the sequence completes. `pf_flush` pulses for one cycle together with `done`.
- R7: A return performs three reads from segment `cur_ss`, at sp, sp+2 and sp+4, giving the new PC, CS and flags in that order. Popped flags are not masked, and `new_sp` becomes sp+6.
- R8: While `mem_req` is high and not yet acknowledged, `mem_seg`, `mem_off`, `mem_we` and `mem_wdata` stay constant. The sequence yields the same results for any number of wait states.
- R9: `done` is high for exactly one cycle at the end of each entry and each return, and `new_pc`, `new_cs`, `new_sp` and `new_flags` hold their final values in that cycle.
- R10: A reset command sets `new_cs` to 0xFFFF and `new_pc` and `new_flags` to 0 in the next cycle. It pulses `seg_clear` and `pf_flush` for one cycle, makes no memory access and raises no `done`.
- R11: `cmd_start` is ignored while a sequence is running, and op 2'b11 in idle has no effect: no memory access, no pulse, no output change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Command strobe, taken only in idle |
| cmd_op | input | 2 | Command code (see R2) |
| int_type | input | 8 | Interrupt type for an entry |
| cur_pc | input | 16 | Current fetch pointer |
| cur_cs | input | 16 | Current code segment |
| cur_ss | input | 16 | Current stack segment |
| cur_sp | input | 16 | Current stack pointer |
| cur_flags | input | 16 | Current flags word |
| queue_len | input | 3 | Bytes held in the prefetch queue |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_seg | output | 16 | Segment of the access |
| mem_off | output | 16 | Offset of the access |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access completes on an edge where `mem_req` and this are high |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| new_pc | output | 16 | Resulting program counter |
| new_cs | output | 16 | Resulting code segment |
| new_sp | output | 16 | Resulting stack pointer |
| new_flags | output | 16 | Resulting flags |
| done | output | 1 | One-cycle pulse: entry or return complete |
| pf_suspend | output | 1 | Prefetch hold, high while a sequence runs |
| pf_flush | output | 1 | One-cycle prefetch flush and restart |
| seg_clear | output | 1 | One-cycle pulse: clear data, extra and stack segments |

## Verification
The hardest cases to reach from the ports are arithmetic wrap-around and a command that arrives while a sequence is running. In the wrap case, the stack pointer lies so low that the pushes cross offset zero, and the prefetch correction underflows the fetch pointer. The stimulus starts an entry with a stack pointer of 2, a fetch pointer of 3 with five queued bytes, and type 0xFF, which also places the vector at the very top of the table. Runs are repeated with several wait-state settings. A return is then aimed at the words that an earlier entry pushed, so each stack write is checked by reading it back through the block itself. A reset command is injected into the middle of a stalled entry, which exercises the busy-ignore path.

// File: rtl/intseq_pkg.sv
package intseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VEC_PC,
        ST_VEC_CS,
        ST_PUSH_FL,
        ST_PUSH_CS,
        ST_PUSH_PC,
        ST_POP_PC,
        ST_POP_CS,
        ST_POP_FL
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_ENTER  = 2'b00,
        OP_RETURN = 2'b01,
        OP_RESET  = 2'b10,
        OP_NONE   = 2'b11
    } seq_op_t;

endpackage

// File: rtl/intseq_addrgen.sv
module intseq_addrgen
    import intseq_pkg::*;
#(
    parameter int          W       = 16,
    parameter int          TYPE_W  = 8,
    parameter logic [W-1:0] VEC_SEG = '0
) (
    input  seq_state_t      state,
    input  logic [TYPE_W-1:0] vtype,
    input  logic [W-1:0]    stk_seg,
    input  logic [W-1:0]    stk_ptr,
    input  logic [W-1:0]    push_fl,
    input  logic [W-1:0]    push_cs,
    input  logic [W-1:0]    push_pc,
    output logic            req,
    output logic            we,
    output logic [W-1:0]    seg,
    output logic [W-1:0]    off,
    output logic [W-1:0]    wdata
);
    // each table entry is two words = four bytes
    localparam int           ENTRY_SHIFT = 2;
    localparam logic [W-1:0] STEP1 = W'(2);
    localparam logic [W-1:0] STEP2 = W'(4);
    localparam logic [W-1:0] STEP3 = W'(6);

    logic [W-1:0] vec_base;
    assign vec_base = {{(W-TYPE_W){1'b0}}, vtype} << ENTRY_SHIFT;

    always_comb begin
        req   = 1'b1;
        we    = 1'b0;
        seg   = stk_seg;
        off   = stk_ptr;
        wdata = '0;
        unique case (state)
            ST_IDLE: begin
                req = 1'b0;
            end
            ST_VEC_PC: begin
                seg = VEC_SEG;
                off = vec_base;
            end
            ST_VEC_CS: begin
                seg = VEC_SEG;
                off = vec_base | STEP1;
            end
            ST_PUSH_FL: begin
                we    = 1'b1;
                off   = stk_ptr - STEP1;
                wdata = push_fl;
            end
            ST_PUSH_CS: begin
                we    = 1'b1;
                off   = stk_ptr - STEP2;
                wdata = push_cs;
            end
            ST_PUSH_PC: begin
                we    = 1'b1;
                off   = stk_ptr - STEP3;
                wdata = push_pc;
            end
            ST_POP_PC: begin
                off = stk_ptr;
            end
            ST_POP_CS: begin
                off = stk_ptr + STEP1;
            end
            ST_POP_FL: begin
                off = stk_ptr + STEP2;
            end
        endcase
    end

endmodule

// File: rtl/intseq_ctrl.sv
module intseq_ctrl
    import intseq_pkg::*;
#(
    parameter int           W        = 16,
    parameter int           TYPE_W   = 8,
    parameter int           QLEN_W   = 3,
    parameter int           IE_BIT   = 9,
    parameter int           TRAP_BIT = 8,
    parameter logic [W-1:0] START_CS = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic [TYPE_W-1:0] int_type,
    input  logic [W-1:0]      cur_pc,
    input  logic [W-1:0]      cur_cs,
    input  logic [W-1:0]      cur_ss,
    input  logic [W-1:0]      cur_sp,
    input  logic [W-1:0]      cur_flags,
    input  logic [QLEN_W-1:0] queue_len,
    input  logic              mem_ack,
    input  logic [W-1:0]      mem_rdata,
    output seq_state_t        state,
    output logic [TYPE_W-1:0] lat_type,
    output logic [W-1:0]      lat_ss,
    output logic [W-1:0]      lat_sp,
    output logic [W-1:0]      lat_fl,
    output logic [W-1:0]      lat_cs,
    output logic [W-1:0]      lat_pcfix,
    output logic [W-1:0]      new_pc,
    output logic [W-1:0]      new_cs,
    output logic [W-1:0]      new_sp,
    output logic [W-1:0]      new_flags,
    output logic              done,
    output logic              pf_flush,
    output logic              seg_clear,
    output logic              pf_suspend
);
    localparam logic [W-1:0] FRAME  = W'(6);
    localparam logic [W-1:0] FLMASK = (W'(1) << IE_BIT) | (W'(1) << TRAP_BIT);

    seq_state_t   nxt;
    logic         idle_take;
    logic         xfer;
    logic         was_entry;
    logic [W-1:0] tmp_pc;
    logic [W-1:0] tmp_cs;

    assign idle_take  = cmd_start && (state == ST_IDLE);
    assign xfer       = (state != ST_IDLE) && mem_ack;
    assign pf_suspend = (state != ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (idle_take) begin
                    if (cmd_op == OP_ENTER)       nxt = ST_VEC_PC;
                    else if (cmd_op == OP_RETURN) nxt = ST_POP_PC;
                end
            end
            ST_VEC_PC:  if (xfer) nxt = ST_VEC_CS;
            ST_VEC_CS:  if (xfer) nxt = ST_PUSH_FL;
            ST_PUSH_FL: if (xfer) nxt = ST_PUSH_CS;
            ST_PUSH_CS: if (xfer) nxt = ST_PUSH_PC;
            ST_PUSH_PC: if (xfer) nxt = ST_IDLE;
            ST_POP_PC:  if (xfer) nxt = ST_POP_CS;
            ST_POP_CS:  if (xfer) nxt = ST_POP_FL;
            ST_POP_FL:  if (xfer) nxt = ST_IDLE;
        endcase
    end

    // outputs and working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_type  <= '0;
            lat_ss    <= '0;
            lat_sp    <= '0;
            lat_fl    <= '0;
            lat_cs    <= '0;
            lat_pcfix <= '0;
            tmp_pc    <= '0;
            tmp_cs    <= '0;
            was_entry <= 1'b0;
            new_pc    <= '0;
            new_cs    <= START_CS;
            new_sp    <= '0;
            new_flags <= '0;
            done      <= 1'b0;
            pf_flush  <= 1'b0;
            seg_clear <= 1'b0;
        end else begin
            done      <= 1'b0;
            pf_flush  <= 1'b0;
            seg_clear <= 1'b0;
            if (idle_take) begin
                if (cmd_op == OP_ENTER || cmd_op == OP_RETURN) begin
                    lat_type  <= int_type;
                    lat_ss    <= cur_ss;
                    lat_sp    <= cur_sp;
                    lat_fl    <= cur_flags;
                    lat_cs    <= cur_cs;
                    lat_pcfix <= cur_pc - W'(queue_len);
                    was_entry <= (cmd_op == OP_ENTER);
                end else if (cmd_op == OP_RESET) begin
                    new_pc    <= '0;
                    new_cs    <= START_CS;
                    new_flags <= '0;
                    pf_flush  <= 1'b1;
                    seg_clear <= 1'b1;
                end
            end
            if (xfer) begin
                case (state)
                    ST_VEC_PC: tmp_pc <= mem_rdata;
                    ST_VEC_CS: tmp_cs <= mem_rdata;
                    ST_PUSH_PC: begin
                        new_pc    <= tmp_pc;
                        new_cs    <= tmp_cs;
                        new_sp    <= lat_sp - FRAME;
                        new_flags <= lat_fl & ~FLMASK;
                        done      <= 1'b1;
                        pf_flush  <= 1'b1;
                    end
                    ST_POP_PC: tmp_pc <= mem_rdata;
                    ST_POP_CS: tmp_cs <= mem_rdata;
                    ST_POP_FL: begin
                        new_pc    <= tmp_pc;
                        new_cs    <= tmp_cs;
                        new_sp    <= lat_sp + FRAME;
                        new_flags <= mem_rdata;
                        done      <= 1'b1;
                        pf_flush  <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_entry_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && was_entry) |-> (!new_flags[IE_BIT] && !new_flags[TRAP_BIT]));

    assert_suspend_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_suspend) |-> $past(cmd_start));

    assert_segclr_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seg_clear |-> ($past(cmd_op) == OP_RESET && !pf_suspend && !done));

    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_suspend && cmd_start) |=> !seg_clear);

endmodule

// File: rtl/int_sequencer.sv
module int_sequencer
    import intseq_pkg::*;
#(
    parameter int W      = 16,
    parameter int TYPE_W = 8,
    parameter int QLEN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic [TYPE_W-1:0] int_type,
    input  logic [W-1:0]      cur_pc,
    input  logic [W-1:0]      cur_cs,
    input  logic [W-1:0]      cur_ss,
    input  logic [W-1:0]      cur_sp,
    input  logic [W-1:0]      cur_flags,
    input  logic [QLEN_W-1:0] queue_len,
    output logic              mem_req,
    output logic              mem_we,
    output logic [W-1:0]      mem_seg,
    output logic [W-1:0]      mem_off,
    output logic [W-1:0]      mem_wdata,
    input  logic              mem_ack,
    input  logic [W-1:0]      mem_rdata,
    output logic [W-1:0]      new_pc,
    output logic [W-1:0]      new_cs,
    output logic [W-1:0]      new_sp,
    output logic [W-1:0]      new_flags,
    output logic              done,
    output logic              pf_suspend,
    output logic              pf_flush,
    output logic              seg_clear
);
    seq_state_t        state;
    logic [TYPE_W-1:0] lat_type;
    logic [W-1:0]      lat_ss, lat_sp, lat_fl, lat_cs, lat_pcfix;

    intseq_ctrl #(
        .W(W), .TYPE_W(TYPE_W), .QLEN_W(QLEN_W),
        .IE_BIT(9), .TRAP_BIT(8), .START_CS('1)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_op    (cmd_op),
        .int_type  (int_type),
        .cur_pc    (cur_pc),
        .cur_cs    (cur_cs),
        .cur_ss    (cur_ss),
        .cur_sp    (cur_sp),
        .cur_flags (cur_flags),
        .queue_len (queue_len),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .state     (state),
        .lat_type  (lat_type),
        .lat_ss    (lat_ss),
        .lat_sp    (lat_sp),
        .lat_fl    (lat_fl),
        .lat_cs    (lat_cs),
        .lat_pcfix (lat_pcfix),
        .new_pc    (new_pc),
        .new_cs    (new_cs),
        .new_sp    (new_sp),
        .new_flags (new_flags),
        .done      (done),
        .pf_flush  (pf_flush),
        .seg_clear (seg_clear),
        .pf_suspend(pf_suspend)
    );

    intseq_addrgen #(
        .W(W), .TYPE_W(TYPE_W), .VEC_SEG('0)
    ) u_addrgen (
        .state  (state),
        .vtype  (lat_type),
        .stk_seg(lat_ss),
        .stk_ptr(lat_sp),
        .push_fl(lat_fl),
        .push_cs(lat_cs),
        .push_pc(lat_pcfix),
        .req    (mem_req),
        .we     (mem_we),
        .seg    (mem_seg),
        .off    (mem_off),
        .wdata  (mem_wdata)
    );

    assert_hold_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_seg) && $stable(mem_off)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    assert_flush_after_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_flush && !seg_clear) |-> $past(mem_req && mem_ack));

endmodule

// File: tb/int_sequencer_bench.sv
`timescale 1ns/1ps
module int_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [1:0]  cmd_op = 2'b11;
    logic [7:0]  int_type = '0;
    logic [15:0] cur_pc = '0, cur_cs = '0, cur_ss = '0, cur_sp = '0, cur_flags = '0;
    logic [2:0]  queue_len = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_seg, mem_off, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] new_pc, new_cs, new_sp, new_flags;
    logic        done, pf_suspend, pf_flush, seg_clear;

    int nchk = 0;
    int nerr = 0;
    int cycles = 0;
    int wait_cfg = 0;
    int wcnt = 0;
    int stab_err = 0;
    int log_n = 0;
    logic [15:0] log_seg [0:63];
    logic [15:0] log_off [0:63];
    logic        log_we  [0:63];
    logic [15:0] log_dat [0:63];
    logic [15:0] stk [bit [31:0]];
    logic        p_req = 1'b0, p_we = 1'b0;
    logic [15:0] p_seg = '0, p_off = '0, p_wd = '0;

    always #4 clk = ~clk;

    int_sequencer u_int_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .int_type(int_type), .cur_pc(cur_pc), .cur_cs(cur_cs), .cur_ss(cur_ss),
        .cur_sp(cur_sp), .cur_flags(cur_flags), .queue_len(queue_len),
        .mem_req(mem_req), .mem_we(mem_we), .mem_seg(mem_seg), .mem_off(mem_off),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .new_pc(new_pc), .new_cs(new_cs), .new_sp(new_sp), .new_flags(new_flags),
        .done(done), .pf_suspend(pf_suspend), .pf_flush(pf_flush), .seg_clear(seg_clear)
    );

    function automatic logic [15:0] vec_pc(input logic [7:0] t);
        return {8'h8A, t};
    endfunction
    function automatic logic [15:0] vec_cs(input logic [7:0] t);
        return {t, 8'h3C};
    endfunction

    function automatic logic [15:0] mem_read(input logic [15:0] s, input logic [15:0] o);
        if (s == 16'h0000) return o[1] ? vec_cs(o[9:2]) : vec_pc(o[9:2]);
        if (stk.exists({s, o})) return stk[{s, o}];
        return o ^ 16'h5A5A;
    endfunction

    // memory model: acknowledge after wait_cfg stall cycles
    always @(negedge clk) begin
        if (mem_req && p_req && !mem_ack &&
            (mem_seg !== p_seg || mem_off !== p_off || mem_we !== p_we || mem_wdata !== p_wd))
            stab_err++;
        p_req = mem_req; p_seg = mem_seg; p_off = mem_off; p_we = mem_we; p_wd = mem_wdata;
        if (mem_req) begin
            if (wcnt >= wait_cfg) begin
                mem_ack   = 1'b1;
                mem_rdata = mem_read(mem_seg, mem_off);
                wcnt      = 0;
            end else begin
                mem_ack = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ack = 1'b0;
            wcnt    = 0;
        end
    end

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            log_seg[log_n] = mem_seg;
            log_off[log_n] = mem_off;
            log_we[log_n]  = mem_we;
            log_dat[log_n] = mem_we ? mem_wdata : mem_rdata;
            if (mem_we) stk[{mem_seg, mem_off}] = mem_wdata;
            log_n = (log_n + 1) % 64;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk + 1, nerr + 1);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op);
        @(negedge clk);
        cmd_op = op;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_log(input int idx, input string req, input logic [15:0] s,
                             input logic [15:0] o, input logic w, input logic [15:0] d);
        int k = idx % 64;
        check(req, "seg", log_seg[k], s);
        check(req, "off", log_off[k], o);
        check(req, "we", {15'b0, log_we[k]}, {15'b0, w});
        check(req, "data", log_dat[k], d);
    endtask

    task automatic t_reset_state;
        check("R1", "new_cs", new_cs, 16'hFFFF);
        check("R1", "new_pc", new_pc, 16'h0000);
        check("R1", "new_sp", new_sp, 16'h0000);
        check("R1", "new_flags", new_flags, 16'h0000);
        check("R1", "pulses", {11'b0, done, pf_flush, seg_clear, pf_suspend, mem_req}, 16'h0);
    endtask

    task automatic t_entry(input logic [7:0] t, input logic [15:0] pc, input logic [15:0] cs,
                           input logic [15:0] ss, input logic [15:0] sp, input logic [15:0] fl,
                           input logic [2:0] q, input int waits);
        int base, n;
        logic [15:0] vb;
        base = log_n;
        wait_cfg = waits;
        int_type = t; cur_pc = pc; cur_cs = cs; cur_ss = ss; cur_sp = sp;
        cur_flags = fl; queue_len = q;
        issue(2'b00);
        check("R6", "suspend after start", {15'b0, pf_suspend}, 16'h1);
        wait_done(n);
        check("R9", "done seen", {15'b0, done}, 16'h1);
        check("R6", "flush with done", {15'b0, pf_flush}, 16'h1);
        check("R6", "suspend released", {15'b0, pf_suspend}, 16'h0);
        check("R2", "new_pc", new_pc, vec_pc(t));
        check("R2", "new_cs", new_cs, vec_cs(t));
        check("R3", "new_sp", new_sp, sp - 16'd6);
        check("R4", "new_flags", new_flags, fl & ~16'h0300);
        vb = {6'b0, t, 2'b00};
        check("R3", "access count", 16'((log_n - base + 64) % 64), 16'd5);
        check_log(base,     "R2", 16'h0000, vb,            1'b0, vec_pc(t));
        check_log(base + 1, "R2", 16'h0000, vb + 16'd2,    1'b0, vec_cs(t));
        check_log(base + 2, "R4", ss,       sp - 16'd2,    1'b1, fl);
        check_log(base + 3, "R3", ss,       sp - 16'd4,    1'b1, cs);
        check_log(base + 4, "R5", ss,       sp - 16'd6,    1'b1, pc - {13'b0, q});
        check("R8", "hold violations", 16'(stab_err), 16'd0);
        @(negedge clk);
        check("R9", "done one cycle", {14'b0, done, pf_flush}, 16'h0);
    endtask

    task automatic t_return(input logic [15:0] ss, input logic [15:0] sp, input int waits,
                            input logic [15:0] epc, input logic [15:0] ecs, input logic [15:0] efl);
        int base, n;
        base = log_n;
        wait_cfg = waits;
        cur_ss = ss; cur_sp = sp;
        issue(2'b01);
        check("R6", "suspend on return", {15'b0, pf_suspend}, 16'h1);
        wait_done(n);
        check("R9", "return done", {14'b0, done, pf_flush}, 16'h3);
        check("R7", "new_pc", new_pc, epc);
        check("R7", "new_cs", new_cs, ecs);
        check("R7", "new_flags", new_flags, efl);
        check("R7", "new_sp", new_sp, sp + 16'd6);
        check("R7", "access count", 16'((log_n - base + 64) % 64), 16'd3);
        check_log(base,     "R7", ss, sp,          1'b0, epc);
        check_log(base + 1, "R7", ss, sp + 16'd2,  1'b0, ecs);
        check_log(base + 2, "R7", ss, sp + 16'd4,  1'b0, efl);
        check("R8", "hold violations", 16'(stab_err), 16'd0);
        @(negedge clk);
        check("R9", "return done one cycle", {15'b0, done}, 16'h0);
    endtask

    task automatic t_reset_cmd;
        int base = log_n;
        issue(2'b10);
        check("R10", "new_cs", new_cs, 16'hFFFF);
        check("R10", "new_pc", new_pc, 16'h0000);
        check("R10", "new_flags", new_flags, 16'h0000);
        check("R10", "pulses", {12'b0, seg_clear, pf_flush, done, pf_suspend}, 16'b1100);
        @(negedge clk);
        check("R10", "pulses end", {14'b0, seg_clear, pf_flush}, 16'h0);
        check("R10", "no access", 16'((log_n - base + 64) % 64), 16'd0);
    endtask

    task automatic t_busy_ignore;
        int n;
        int seen = 0;
        wait_cfg = 2;
        int_type = 8'h42; cur_pc = 16'h0500; cur_cs = 16'h0600; cur_ss = 16'h0900;
        cur_sp = 16'h0400; cur_flags = 16'h0302; queue_len = 3'd2;
        issue(2'b00);
        @(negedge clk);
        cmd_op = 2'b10; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        if (seg_clear) seen++;
        n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            if (seg_clear) seen++;
            n++;
        end
        check("R11", "no reset while busy", 16'(seen), 16'd0);
        check("R11", "entry pc kept", new_pc, vec_pc(8'h42));
        check("R11", "entry cs kept", new_cs, vec_cs(8'h42));
        @(negedge clk);
    endtask

    task automatic t_noop;
        int base = log_n;
        int act = 0;
        logic [15:0] pc0 = new_pc;
        issue(2'b11);
        repeat (3) begin
            if (pf_suspend || pf_flush || seg_clear || done || mem_req) act++;
            @(negedge clk);
        end
        check("R11", "noop activity", 16'(act), 16'd0);
        check("R11", "noop accesses", 16'((log_n - base + 64) % 64), 16'd0);
        check("R11", "noop pc", new_pc, pc0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_entry(8'h21, 16'h1234, 16'h4000, 16'h3000, 16'h0100, 16'h0B46, 3'd3, 0);
        t_return(16'h3000, 16'h00FA, 2, 16'h1231, 16'h4000, 16'h0B46);
        t_entry(8'hFF, 16'h0003, 16'h0100, 16'h0700, 16'h0002, 16'h0001, 3'd5, 3);
        t_entry(8'h00, 16'h8000, 16'h0010, 16'h0700, 16'h0800, 16'h0200, 3'd0, 1);
        t_return(16'h5000, 16'h0200, 0, 16'h585A, 16'h5858, 16'h585E);
        t_reset_cmd();
        t_busy_ignore();
        t_noop();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule